// File: doc/BRIEF.md
# Lockstep Pseudo-Random Generator with Fault Detection

This block produces pseudo-random bits from a linear feedback shift register that is kept twice. Both copies share every input: clock, reset, advance enable, entropy word and seed load. They should therefore hold the same state in every cycle. A comparator checks the two full states continuously. Any disagreement, for example after a glitch that flips a flop in one copy, raises a mismatch flag in the same cycle.

Consumers receive a subset of the state bits. These bits are taken after a fixed bit shuffle that is set at compile time. Entropy can be XORed into the next state during any advance. An external seed can replace the state at any time. A state that would become all-zero is replaced by the default seed, so the register can never lock up.

Top module: `dual_lfsr_guard`

## Requirements
- R1: While reset is active, and after it is released, both copies hold the default seed (16'hACE1 by default), `mismatch_o` is low and `rnd_o` shows the shuffled seed.
- R2: When `adv_i` and `seed_load_i` are both low, the state does not change. `entropy_i` has no effect in that cycle.
- R3: On an advance with zero entropy, the state steps as a right-shifting Galois register: next = (s >> 1) XOR (s[0] ? TAP : 0), where TAP = 16'hB400 for width 16. From any nonzero state, the sequence returns to that state after exactly 2^16-1 steps.
- R4: On an advance, the zero-extended `entropy_i` is XORed into the stepped value of both copies.
- R5: If an advance would produce the all-zero state, the default seed is loaded instead.
- R6: `seed_load_i` takes priority over `adv_i` and loads `seed_i`. A zero `seed_i` loads the default seed instead.
- R7: `rnd_o[j]` equals state bit ((j*5 + 3) mod 16) for j from 0 to OUT_W-1, with OUT_W = 8 by default.
- R8: `mismatch_o` is high in the same cycle that the two copies differ in any bit, and stays high while they differ.
- R9: With no fault present, `mismatch_o` never rises under any mix of advance, entropy and seed-load stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Advance both copies one step |
| seed_load_i | input | 1 | Load `seed_i` into both copies |
| seed_i | input | LFSR_W | External seed value |
| entropy_i | input | ENT_W | Entropy word mixed in on an advance |
| rnd_o | output | OUT_W | Shuffled subset of the state |
| mismatch_o | output | 1 | High while the two copies disagree |

## Verification
The mismatch condition cannot be reached through the ports. Every input drives both copies identically, so no stimulus sequence makes them diverge. The bench gets there by forcing one flop of the second copy to the complement of the expected bit between clock edges. It checks that the flag is high at once, that it stays high after the force is released and the copies keep stepping, and that reset clears it. The lockup escape is reached from the ports. The bench computes the stepped value of the known state and supplies it as the entropy word, so the XOR lands exactly on zero.

// File: rtl/dlfsr_pkg.sv
package dlfsr_pkg;

  // Right-shift Galois feedback masks of maximal length
  function automatic logic [63:0] tap_mask(input int unsigned w);
    case (w)
      8:       return 64'h00000000000000B8;
      16:      return 64'h000000000000B400;
      24:      return 64'h0000000000E10000;
      32:      return 64'h00000000A3000000;
      64:      return 64'hD800000000000000;
      default: return 64'h000000000000B400;
    endcase
  endfunction

  // Source bit for output position j; mul must be coprime to w
  function automatic int unsigned perm_src(input int unsigned j, input int unsigned w,
                                           input int unsigned mul, input int unsigned add);
    return (j * mul + add) % w;
  endfunction

endpackage

// File: rtl/dlfsr_core.sv
module dlfsr_core import dlfsr_pkg::*; #(
  parameter int unsigned W     = 16,
  parameter int unsigned ENT_W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic [W-1:0]  seed_i,
  input  logic [ENT_W-1:0] ent_i,
  output logic [W-1:0]  state_o
);
  localparam logic [W-1:0] TAPS = W'(tap_mask(W));

  logic [W-1:0] state_q, state_d, stepped, mixed, cand, ent_ext;

  assign ent_ext = W'(ent_i);
  assign stepped = (state_q >> 1) ^ ({W{state_q[0]}} & TAPS);
  assign mixed   = stepped ^ ent_ext;

  always_comb begin
    if (load_i)     cand = seed_i;
    else if (adv_i) cand = mixed;
    else            cand = state_q;
    // lockup escape
    state_d = (cand == '0) ? SEED : cand;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(state_q));

  // R5
  no_lockup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  // R6
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> state_q == $past(seed_i));

  // R3
  step_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && ent_i == '0) |=> state_q != $past(state_q));

endmodule

// File: rtl/dlfsr_permute.sv
module dlfsr_permute import dlfsr_pkg::*; #(
  parameter int unsigned W     = 16,
  parameter int unsigned OUT_W = 8,
  parameter int unsigned MUL   = 5,
  parameter int unsigned ADD   = 3
) (
  input  logic [W-1:0]     state_i,
  output logic [OUT_W-1:0] bits_o
);
  for (genvar j = 0; j < OUT_W; j++) begin : g_bit
    localparam int unsigned SRC = perm_src(j, W, MUL, ADD);
    assign bits_o[j] = state_i[SRC];
  end
endmodule

// File: rtl/dlfsr_compare.sv
module dlfsr_compare #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         diff_o
);
  logic [W-1:0] bit_diff;

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign bit_diff[i] = a_i[i] ^ b_i[i];
  end

  assign diff_o = |bit_diff;

  // R8
  diff_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != b_i) |-> diff_o);
endmodule

// File: rtl/dual_lfsr_guard.sv
module dual_lfsr_guard #(
  parameter int unsigned LFSR_W   = 16,
  parameter int unsigned ENT_W    = 16,
  parameter int unsigned OUT_W    = 8,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter int unsigned PERM_MUL = 5,
  parameter int unsigned PERM_ADD = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic [ENT_W-1:0]  entropy_i,
  output logic [OUT_W-1:0]  rnd_o,
  output logic              mismatch_o
);
  logic [LFSR_W-1:0] state_a, state_b;

  dlfsr_core #(.W(LFSR_W), .ENT_W(ENT_W), .SEED(SEED)) u_core_a (
    .clk_i, .rst_ni, .adv_i, .load_i(seed_load_i), .seed_i,
    .ent_i(entropy_i), .state_o(state_a)
  );

  dlfsr_core #(.W(LFSR_W), .ENT_W(ENT_W), .SEED(SEED)) u_core_b (
    .clk_i, .rst_ni, .adv_i, .load_i(seed_load_i), .seed_i,
    .ent_i(entropy_i), .state_o(state_b)
  );

  dlfsr_compare #(.W(LFSR_W)) u_cmp (
    .clk_i, .rst_ni, .a_i(state_a), .b_i(state_b), .diff_o(mismatch_o)
  );

  dlfsr_permute #(.W(LFSR_W), .OUT_W(OUT_W), .MUL(PERM_MUL), .ADD(PERM_ADD)) u_perm (
    .state_i(state_a), .bits_o(rnd_o)
  );
endmodule

// File: tb/dual_lfsr_guard_tb.sv
module dual_lfsr_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] TAP  = 16'hB400;

  logic clk = 0, rst_ni = 0, adv = 0, load = 0, fault_on = 0;
  logic [15:0] seed_in = '0, ent = '0, model = SEED;
  logic [7:0] rnd;
  logic mism;
  int total = 0, bad = 0, spurious = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lfsr_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .adv_i(adv), .seed_load_i(load),
    .seed_i(seed_in), .entropy_i(ent), .rnd_o(rnd), .mismatch_o(mism)
  );

  function automatic logic [15:0] gstep(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? TAP : 16'h0);
  endfunction

  function automatic logic [7:0] shuf(input logic [15:0] s);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = s[(j*5+3)%16];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic l, input logic [15:0] s, input logic [15:0] e);
    logic [15:0] t;
    @(negedge clk);
    adv = a; load = l; seed_in = s; ent = e;
    @(posedge clk);
    #1;
    if (l) model = (s == 0) ? SEED : s;
    else if (a) begin
      t = gstep(model) ^ e;
      model = (t == 0) ? SEED : t;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; adv = 0; load = 0; ent = 0; seed_in = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    model = SEED;
    #1;
  endtask

  always @(negedge clk) if (rst_ni && !fault_on && mism) spurious++;

  task automatic t_reset();
    @(negedge clk); rst_ni = 0; #1;
    chk("R1 out in reset", rnd, shuf(SEED));
    chk("R1 mismatch in reset", mism, 0);
    do_reset();
    chk("R1 out after reset", rnd, shuf(SEED));
  endtask

  task automatic t_hold();
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 16'h5A5A);
    chk("R2 R4 hold ignores entropy", rnd, shuf(model));
    cyc(1, 0, 0, 0);
    chk("R2 resumes after hold", rnd, shuf(model));
  endtask

  task automatic t_step();
    int errs = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1, 0, 0, 0);
      if (rnd !== shuf(model)) errs++;
    end
    chk("R3 short step run", errs, 0);
  endtask

  task automatic t_entropy();
    cyc(1, 0, 0, 16'h8001);
    chk("R4 entropy mix a", rnd, shuf(model));
    cyc(1, 0, 0, 16'h3C96);
    chk("R4 entropy mix b", rnd, shuf(model));
  endtask

  task automatic t_lockup();
    logic [15:0] e;
    e = gstep(model);
    cyc(1, 0, 0, e);
    chk("R5 lockup model", model, SEED);
    chk("R5 lockup escape", rnd, shuf(SEED));
    cyc(1, 0, 0, 0);
    chk("R5 steps from seed", rnd, shuf(gstep(SEED)));
  endtask

  task automatic t_load();
    cyc(1, 1, 16'h1234, 16'hFFFF);
    chk("R6 load beats advance", rnd, shuf(16'h1234));
    cyc(1, 0, 0, 0);
    chk("R6 steps from loaded", rnd, shuf(gstep(16'h1234)));
    cyc(0, 1, 16'h0000, 0);
    chk("R6 zero seed gives default", rnd, shuf(SEED));
  endtask

  task automatic t_perm();
    for (int k = 0; k < 16; k++) begin
      cyc(0, 1, 16'h1 << k, 0);
      chk("R7 shuffle one-hot", rnd, shuf(16'h1 << k));
    end
  endtask

  task automatic t_period();
    int errs = 0;
    do_reset();
    for (int i = 1; i <= 65535; i++) begin
      cyc(1, 0, 0, 0);
      if (rnd !== shuf(model)) errs++;
      if (i < 65535 && model == SEED) errs++;
    end
    chk("R3 R7 full period sequence", errs, 0);
    chk("R3 period returns to seed", rnd, shuf(SEED));
  endtask

  task automatic t_fault();
    @(negedge clk);
    fault_on = 1;
    force u_dut.u_core_b.state_q = model ^ 16'h0010;
    #1;
    chk("R8 mismatch same cycle", mism, 1);
    release u_dut.u_core_b.state_q;
    cyc(1, 0, 0, 0);
    chk("R8 mismatch persists", mism, 1);
    do_reset();
    chk("R8 reset clears mismatch", mism, 0);
    fault_on = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_step();
    t_entropy();
    t_lockup();
    t_load();
    t_perm();
    t_period();
    chk("R9 no spurious mismatch", spurious, 0);
    t_fault();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule